// File: doc/BRIEF.md
# Cascadable Reload Timer Bank

A bank of down-counting interval timers, four by default, each eight bits wide, behind a small byte-addressed register bus. Every timer owns a mode register, a reload (base) register and a read-only counter. A running timer counts down on a shared prescaled tick. When its period has elapsed it raises its underflow output for one clock cycle, which can be used as an interrupt request, and then starts the next period from its base value.

Two neighbouring timers can be joined into one wider counter. The upper timer is put in the chained clock mode first. The lower timer is then enabled on the tick, and the pair counts a single period built from both base registers. A checker flags illegal register accesses in a sticky error bit. Such accesses change no state. A separate clear input resets the bit.

Top module: `reload_timer_bank`

## Requirements
- R1: After reset every mode, base and counter register reads zero, all underflow outputs are low and the error flag is low.
- R2: Page 0x0_ holds the mode registers, page 0x1_ the bases and page 0x2_ the counters, with the timer index in the low nibble. The size code is 0 for byte, 1 for 16 bits and 2 for 32 bits. Byte reads return the register in bits 7:0. A 16-bit read at timer 0 or 2 returns timer n in bits 15:8 and timer n+1 in bits 7:0. A 32-bit read at timer 0 returns timer 0 in bits 31:24 down to timer 3 in bits 7:0.
- R3: While a timer is not counting, its counter follows its base register one cycle after a base write, so a counter read then returns the base value.
- R4: A base write to a counting timer leaves the current count alone and only sets the value reloaded at the next underflow.
- R5: Mode bit 7 enables counting and bits 1:0 pick the source, where 00 means the common tick. A counting timer with base B loses one count per tick, and its counter reads the ticks left. On the B-th tick it raises its underflow output for exactly one cycle and reloads B.
- R6: Clearing bit 7 stops a timer, and no underflow occurs afterwards. An enabled timer whose effective period is zero never underflows.
- R7: When timer n+1 has bit 7 set with source code 11 (chained), enabling timer n on the tick makes the pair count a period of base[n+1]*256 + base[n] ticks. Only timer n's underflow output pulses, and a 16-bit counter read at n returns {count n, count n+1}.
- R8: A mode write is rejected and raises the error flag in any of these cases: it is not byte-sized, it sets any of bits 5:2, it sets both bit 7 and bit 6 (load), or it selects source 11 on timer 0.
- R9: A write to a counter raises the error flag. So does any access to an unmapped offset, and so does any 16-bit access at an odd timer or 32-bit access at a non-zero timer. A rejected access changes no register and reads as zero.
- R10: The error flag stays set until err_clr is driven high. A legal access never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Common prescaled count tick, one cycle per count |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_size | input | 2 | Access size: 0 byte, 1 16-bit, 2 32-bit |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, valid in the cycle bus_rd is high |
| err_clr | input | 1 | Clears the sticky error flag |
| err_flag | output | 1 | Sticky illegal-access flag |
| uflow | output | 4 | One-cycle underflow pulse per timer |

## Verification
Most internal faults in this block show up at the ports within one period. A wrong terminal test or a wrong reload value moves the underflow pulse by at least one tick, and the counter read in the following cycle no longer matches the base. A broken borrow between chained timers only appears once the low byte wraps. For that reason the chained pair is read in the middle of its period and again right after its single pulse. A mode register that wrongly took a rejected write becomes visible at the next mode read. An error flag that fails to set appears on the clock edge that captured the bad access.

// File: rtl/rtb_pkg.sv
// Shared constants and types of the reload timer bank.
// Assumes eight-bit mode registers and a 16-byte address page per register class.
package rtb_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        GRP_MODE,
        GRP_BASE,
        GRP_CNT,
        GRP_NONE
    } reg_grp_e;

    localparam int PG_MODE = 0;
    localparam int PG_BASE = 1;
    localparam int PG_CNT  = 2;

    localparam int BIT_CE = 7;
    localparam int BIT_LD = 6;

    localparam logic [1:0] SRC_TICK  = 2'b00;
    localparam logic [1:0] SRC_CHAIN = 2'b11;
endpackage

// File: rtl/rtb_regs.sv
// Register file and bus decoder of the timer bank.
// Holds the mode and base registers, checks every access for legal size and
// content, muxes read data and keeps the sticky error flag.
// Assumes N >= 2 and a 4-bit index field in bus_addr[3:0].
module rtb_regs
    import rtb_pkg::*;
#(
    parameter int N  = 4,
    parameter int TW = 8,
    parameter int AW = 8,
    localparam int DW = N * TW,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [AW-1:0]        bus_addr,
    input  logic [1:0]           bus_size,
    input  logic [DW-1:0]        bus_wdata,
    input  logic                 err_clr,
    input  logic [N-1:0][TW-1:0] cnt_i,
    output logic [N-1:0][7:0]    mode_o,
    output logic [N-1:0][TW-1:0] base_o,
    output logic [DW-1:0]        bus_rdata,
    output logic                 err_flag
);
    logic [N-1:0][7:0]    mode_q;
    logic [N-1:0][TW-1:0] base_q;
    logic                 err_q;
    acc_size_e            sz;
    reg_grp_e             grp;
    logic [IW-1:0]        idx;
    logic [IW-1:0]        idx_nx;
    logic                 size_ok;
    logic                 mode_ok;
    logic                 rd_ok;
    logic                 wr_ok;
    logic [TW-1:0]        rv [N];

    assign sz     = acc_size_e'(bus_size);
    assign idx    = bus_addr[IW-1:0];
    assign idx_nx = idx + IW'(1);

    // Classify the address into a register group
    always_comb begin
        grp = GRP_NONE;
        if (int'(bus_addr[3:0]) < N) begin
            if (int'(bus_addr[AW-1:4]) == PG_MODE)      grp = GRP_MODE;
            else if (int'(bus_addr[AW-1:4]) == PG_BASE) grp = GRP_BASE;
            else if (int'(bus_addr[AW-1:4]) == PG_CNT)  grp = GRP_CNT;
        end
    end

    // Decide whether the access width fits the addressed timer
    always_comb begin
        case (sz)
            SZ_BYTE: size_ok = 1'b1;
            SZ_HALF: size_ok = (idx[0] == 1'b0) && (int'(idx) + 1 < N);
            SZ_WORD: size_ok = (idx == '0);
            default: size_ok = 1'b0;
        endcase
    end

    // Legal mode contents: reserved bits clear, no load with enable, no chain on timer 0
    assign mode_ok = (bus_wdata[5:2] == 4'b0)
                  && !(bus_wdata[BIT_CE] && bus_wdata[BIT_LD])
                  && !((idx == '0) && (bus_wdata[1:0] == SRC_CHAIN));

    assign rd_ok = (grp != GRP_NONE) && size_ok;
    assign wr_ok = ((grp == GRP_BASE) && size_ok)
                || ((grp == GRP_MODE) && (sz == SZ_BYTE) && mode_ok);

    // Per-timer value of the addressed register group
    always_comb begin
        for (int k = 0; k < N; k++) begin
            case (grp)
                GRP_MODE: rv[k] = TW'(mode_q[k]);
                GRP_BASE: rv[k] = base_q[k];
                GRP_CNT:  rv[k] = cnt_i[k];
                default:  rv[k] = '0;
            endcase
        end
    end

    // Pack read data by access size, timer n in the most significant lane
    always_comb begin
        bus_rdata = '0;
        if (bus_rd && rd_ok) begin
            case (sz)
                SZ_BYTE: bus_rdata[TW-1:0]   = rv[idx];
                SZ_HALF: bus_rdata[2*TW-1:0] = {rv[idx], rv[idx_nx]};
                SZ_WORD: begin
                    for (int k = 0; k < N; k++) begin
                        bus_rdata[DW-1-k*TW -: TW] = rv[k];
                    end
                end
                default: bus_rdata = '0;
            endcase
        end
    end

    // Apply legal writes to mode and base registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            base_q <= '0;
        end else if (bus_wr && wr_ok) begin
            if (grp == GRP_MODE) begin
                mode_q[idx] <= bus_wdata[7:0];
            end else begin
                case (sz)
                    SZ_BYTE: base_q[idx] <= bus_wdata[TW-1:0];
                    SZ_HALF: begin
                        base_q[idx]    <= bus_wdata[2*TW-1:TW];
                        base_q[idx_nx] <= bus_wdata[TW-1:0];
                    end
                    SZ_WORD: begin
                        for (int k = 0; k < N; k++) begin
                            base_q[k] <= bus_wdata[DW-1-k*TW -: TW];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Sticky error flag, a new error wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if ((bus_wr && !wr_ok) || (bus_rd && !rd_ok)) begin
            err_q <= 1'b1;
        end else if (err_clr) begin
            err_q <= 1'b0;
        end
    end

    assign mode_o   = mode_q;
    assign base_o   = base_q;
    assign err_flag = err_q;
endmodule

// File: rtl/rtb_link.sv
// Sequencing logic of the timer bank, purely combinational.
// Works out for each timer whether it runs, decrements, reloads or fires,
// including the borrow and shared reload of a chained pair.
// Assumes a timer in chained mode is driven only by the timer just below it.
module rtb_link
    import rtb_pkg::*;
#(
    parameter int N  = 4,
    parameter int TW = 8
) (
    input  logic                 tick,
    input  logic [N-1:0][7:0]    mode_i,
    input  logic [N-1:0][TW-1:0] base_i,
    input  logic [N-1:0][TW-1:0] cnt_i,
    output logic [N-1:0]         run_o,
    output logic [N-1:0]         dec_o,
    output logic [N-1:0]         reload_o,
    output logic [N-1:0]         fire_o
);
    logic [N-1:0] mst;
    logic [N-1:0] wide;
    logic [N-1:0] nz;
    logic [N-1:0] term;
    logic [N-1:0] mrun;
    logic [N-1:0] wrun;

    for (genvar g = 0; g < N; g++) begin : g_tmr
        // A master counts on the common tick
        assign mst[g] = mode_i[g][BIT_CE] && (mode_i[g][1:0] == SRC_TICK);

        if (g < N - 1) begin : g_pair
            // Join with the upper neighbour when it waits in chained mode
            assign wide[g] = mst[g] && mode_i[g+1][BIT_CE]
                          && (mode_i[g+1][1:0] == SRC_CHAIN);
            assign nz[g]   = (base_i[g] != '0) || (wide[g] && (base_i[g+1] != '0));
            assign term[g] = wide[g] ? ((cnt_i[g+1] == '0) && (cnt_i[g] < TW'(2)))
                                     : (cnt_i[g] < TW'(2));
        end else begin : g_last
            assign wide[g] = 1'b0;
            assign nz[g]   = (base_i[g] != '0);
            assign term[g] = (cnt_i[g] < TW'(2));
        end

        assign mrun[g]   = mst[g] && nz[g];
        assign wrun[g]   = mrun[g] && wide[g];
        assign fire_o[g] = mrun[g] && tick && term[g];

        if (g > 0) begin : g_slave
            // Upper half of a pair follows the borrow and reload of its master
            assign run_o[g]    = mrun[g] || wrun[g-1];
            assign reload_o[g] = fire_o[g] || (wrun[g-1] && fire_o[g-1]);
            assign dec_o[g]    = (mrun[g] && tick)
                              || (wrun[g-1] && tick && (cnt_i[g-1] == '0));
        end else begin : g_first
            assign run_o[g]    = mrun[g];
            assign reload_o[g] = fire_o[g];
            assign dec_o[g]    = mrun[g] && tick;
        end
    end
endmodule

// File: rtl/rtb_slot.sv
// One counter of the timer bank.
// Follows its base while idle; while running it reloads or decrements as told.
// Assumes reload and decrement are never needed together (reload wins).
module rtb_slot #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          dec,
    input  logic          reload,
    input  logic [TW-1:0] base,
    output logic [TW-1:0] cnt_o
);
    logic [TW-1:0] cnt_q;

    // Count state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || reload) begin
            cnt_q <= base;
        end else if (dec) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/reload_timer_bank.sv
// Top of the cascadable reload timer bank.
// Joins the register file, the sequencing logic and one counter per timer,
// and registers the underflow pulses.
// Assumes tick is a one-cycle strobe synchronous to clk.
module reload_timer_bank #(
    parameter int N_TMR = 4,
    parameter int TW    = 8,
    parameter int AW    = 8,
    localparam int DW   = N_TMR * TW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [AW-1:0]    bus_addr,
    input  logic [1:0]       bus_size,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic             err_clr,
    output logic             err_flag,
    output logic [N_TMR-1:0] uflow
);
    logic [N_TMR-1:0][7:0]    mode_w;
    logic [N_TMR-1:0][TW-1:0] base_w;
    logic [N_TMR-1:0][TW-1:0] cnt_w;
    logic [N_TMR-1:0]         run_w;
    logic [N_TMR-1:0]         dec_w;
    logic [N_TMR-1:0]         rld_w;
    logic [N_TMR-1:0]         fire_w;
    logic [N_TMR-1:0]         uflow_q;

    rtb_regs #(.N(N_TMR), .TW(TW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .err_clr   (err_clr),
        .cnt_i     (cnt_w),
        .mode_o    (mode_w),
        .base_o    (base_w),
        .bus_rdata (bus_rdata),
        .err_flag  (err_flag)
    );

    rtb_link #(.N(N_TMR), .TW(TW)) u_link (
        .tick     (tick),
        .mode_i   (mode_w),
        .base_i   (base_w),
        .cnt_i    (cnt_w),
        .run_o    (run_w),
        .dec_o    (dec_w),
        .reload_o (rld_w),
        .fire_o   (fire_w)
    );

    for (genvar g = 0; g < N_TMR; g++) begin : g_slot
        rtb_slot #(.TW(TW)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run_w[g]),
            .dec    (dec_w[g]),
            .reload (rld_w[g]),
            .base   (base_w[g]),
            .cnt_o  (cnt_w[g])
        );
    end

    // Underflow pulse register, one cycle per terminal tick
    always_ff @(posedge clk) begin
        if (!rst_n) uflow_q <= '0;
        else        uflow_q <= fire_w;
    end

    assign uflow = uflow_q;
endmodule

// File: rtl/rtb_checks.sv
// Property checker for the reload timer bank, attached by bind.
// Observes ports and the mode registers driven by the register file.
module rtb_checks #(
    parameter int N  = 4,
    parameter int AW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              bus_wr,
    input logic [AW-1:0]     bus_addr,
    input logic              err_clr,
    input logic              err_flag,
    input logic [N-1:0]      uflow,
    input logic [N-1:0][7:0] mode_w
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (uflow == '0) && !err_flag);

    // R9
    cnt_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (int'(bus_addr[AW-1:4]) == 2)) |=> err_flag);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);

    // R8
    no_chain_t0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_w[0][1:0] != 2'b11);

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R5
        uflow_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
            uflow[g] |-> $past(tick));

        // R8
        mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_w[g][5:2] == 4'b0) && !(mode_w[g][7] && mode_w[g][6]));

        if (g > 0) begin : g_up
            // R7
            slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_w[g][7] && (mode_w[g][1:0] == 2'b11)) |=> !uflow[g]);
        end
    end
endmodule

bind reload_timer_bank rtb_checks #(.N(N_TMR), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .err_clr  (err_clr),
    .err_flag (err_flag),
    .uflow    (uflow),
    .mode_w   (mode_w)
);

// File: tb/sim_reload_timer_bank.sv
// Scoreboard bench for reload_timer_bank: read tasks queue expected data,
// a negedge monitor pops and compares it and counts underflow pulses.
module sim_reload_timer_bank;
    localparam int N  = 4;
    localparam int TW = 8;
    localparam int AW = 8;
    localparam int DW = N * TW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [1:0]    bus_size = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic          err_clr = 1'b0;
    logic [DW-1:0] bus_rdata;
    logic          err_flag;
    logic [N-1:0]  uflow;

    int checks = 0;
    int fails = 0;
    int ucnt [N] = '{default: 0};
    int snap2;
    int snap3;

    typedef struct {
        logic [DW-1:0] exp;
        string         req;
    } item_t;
    item_t sbq [$];
    item_t mon_it;

    always #4 clk = ~clk;

    reload_timer_bank u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .err_clr   (err_clr),
        .err_flag  (err_flag),
        .uflow     (uflow)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: count underflow pulses and score read data
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < N; i++) if (uflow[i]) ucnt[i]++;
        end
        if (bus_rd) begin
            if (sbq.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL scoreboard read with no expected item actual=%h expected=none", bus_rdata);
            end else begin
                mon_it = sbq.pop_front();
                chk(mon_it.req, bus_rdata, mon_it.exp);
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [7:0] a, input logic [1:0] s, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d;
        cyc();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [1:0] s, input logic [31:0] e, input string req);
        item_t it;
        it.exp = e;
        it.req = req;
        sbq.push_back(it);
        bus_rd = 1'b1; bus_addr = a; bus_size = s;
        cyc();
        bus_rd = 1'b0;
    endtask

    task automatic tickp();
        tick = 1'b1;
        cyc();
        tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) cyc();
        tick = 1'b0;
    endtask

    task automatic clr_err();
        err_clr = 1'b1;
        cyc();
        err_clr = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state
        chk("R1 err_flag", 32'(err_flag), 0);
        chk("R1 uflow", 32'(uflow), 0);
        rd(8'h00, 2'd2, 32'h0, "R1 modes");
        rd(8'h10, 2'd2, 32'h0, "R1 bases");
        rd(8'h20, 2'd2, 32'h0, "R1 counters");

        // R3 base write while stopped loads counter
        wr(8'h10, 2'd0, 32'h03);
        cyc();
        rd(8'h20, 2'd0, 32'h03, "R3 idle counter follows base");

        // R5 counting and underflow
        wr(8'h00, 2'd0, 32'h80);
        tickp();
        tickp();
        chk("R5 no early uflow", 32'(uflow[0]), 0);
        rd(8'h20, 2'd0, 32'h01, "R5 ticks remaining");
        tickp();
        chk("R5 uflow on third tick", 32'(uflow[0]), 1);
        cyc();
        chk("R5 uflow one cycle", 32'(uflow[0]), 0);
        rd(8'h20, 2'd0, 32'h03, "R5 reload from base");

        // R4 base write while counting
        wr(8'h10, 2'd0, 32'h05);
        cyc();
        cyc();
        rd(8'h20, 2'd0, 32'h03, "R4 count kept");
        tickp();
        tickp();
        tickp();
        chk("R4 uflow at old period", 32'(uflow[0]), 1);
        cyc();
        rd(8'h20, 2'd0, 32'h05, "R4 new reload value");

        // R6 stop, R3 stopped read returns base
        tickp();
        rd(8'h20, 2'd0, 32'h04, "R5 decremented");
        wr(8'h00, 2'd0, 32'h00);
        cyc();
        rd(8'h20, 2'd0, 32'h05, "R3 stopped counter reads base");
        snap2 = ucnt[0];
        ticks(10);
        cyc();
        chk("R6 stopped timer silent", 32'(ucnt[0] - snap2), 0);

        // R6 zero period
        wr(8'h01, 2'd0, 32'h80);
        snap2 = ucnt[1];
        ticks(10);
        cyc();
        chk("R6 zero period silent", 32'(ucnt[1] - snap2), 0);

        // R7 chained pair 2/3, period 0x0102
        wr(8'h13, 2'd0, 32'h01);
        wr(8'h12, 2'd1, 32'h0201);
        wr(8'h03, 2'd0, 32'h83);
        wr(8'h02, 2'd0, 32'h80);
        snap2 = ucnt[2];
        snap3 = ucnt[3];
        ticks(200);
        rd(8'h22, 2'd1, 32'h3A00, "R7 chained count mid period");
        ticks(57);
        cyc();
        chk("R7 no early chained uflow", 32'(ucnt[2] - snap2), 0);
        tickp();
        chk("R7 chained uflow on tick 258", 32'(uflow[2]), 1);
        cyc();
        rd(8'h22, 2'd1, 32'h0201, "R7 chained reload");
        chk("R7 upper timer silent", 32'(ucnt[3] - snap3), 0);

        // R2 packing
        rd(8'h00, 2'd2, 32'h00808083, "R2 word mode read");
        rd(8'h10, 2'd2, 32'h05000201, "R2 word base read");
        rd(8'h00, 2'd1, 32'h00000080, "R2 half mode read");
        rd(8'h03, 2'd0, 32'h00000083, "R2 byte mode read");

        // R8 illegal mode writes
        wr(8'h00, 2'd1, 32'h0080);
        chk("R8 half mode write flagged", 32'(err_flag), 1);
        rd(8'h00, 2'd0, 32'h0, "R8 half mode write ignored");
        clr_err();
        chk("R10 cleared", 32'(err_flag), 0);
        wr(8'h00, 2'd0, 32'hC0);
        chk("R8 load with enable flagged", 32'(err_flag), 1);
        clr_err();
        wr(8'h00, 2'd0, 32'h84);
        chk("R8 reserved bits flagged", 32'(err_flag), 1);
        clr_err();
        wr(8'h00, 2'd0, 32'h83);
        chk("R8 timer0 chain flagged", 32'(err_flag), 1);
        rd(8'h00, 2'd0, 32'h0, "R8 rejected modes ignored");
        clr_err();

        // R9 counter write and bad widths
        wr(8'h21, 2'd0, 32'h55);
        chk("R9 counter write flagged", 32'(err_flag), 1);
        clr_err();
        rd(8'h21, 2'd0, 32'h0, "R9 counter unchanged");
        rd(8'h11, 2'd1, 32'h0, "R9 odd half read is zero");
        chk("R9 odd half read flagged", 32'(err_flag), 1);
        clr_err();
        wr(8'h12, 2'd2, 32'hFFFFFFFF);
        chk("R9 word write at timer2 flagged", 32'(err_flag), 1);
        clr_err();
        rd(8'h12, 2'd0, 32'h02, "R9 base unchanged");

        // R10 sticky flag
        wr(8'h40, 2'd0, 32'h0);
        repeat (5) cyc();
        chk("R10 flag held", 32'(err_flag), 1);
        clr_err();
        wr(8'h11, 2'd0, 32'h07);
        cyc();
        chk("R10 legal write leaves flag low", 32'(err_flag), 0);

        cyc();
        chk("scoreboard drained", 32'(sbq.size()), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule